// File: doc/BRIEF.md
# Store Byte-Lane Steering and Enable Generator

This block turns one store request into the shape a 256-bit write port to a second-level cache expects. The request carries a byte address, a size code, a flag for the auxiliary execution unit as the source, and data that is packed at the low end of the data input. The block moves that data up to the byte lanes the address selects and produces 32 byte-enable bits. Only the bytes being written are enabled. All other lanes carry zero data.

Writes of 1, 2, 4, 8 and 16 bytes are always accepted. A full 32-byte write is accepted only when the wide-write mode input is high and the request comes from the auxiliary unit. A request is rejected if it is misaligned, uses an unknown size code, or is a 32-byte write that is not allowed. A rejected request produces no enables and raises an error flag for exactly one cycle. Every result appears in the clock cycle after the request.

Top module: `store_lane_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wr_valid`, `wr_err`, `wr_be` and `wr_data` are all zero.
- R2: Every output is registered. A request sampled at a clock edge is reflected at the outputs after that same edge. A cycle without `req_valid` produces all-zero outputs on the next cycle.
- R3: Size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes. An aligned request with one of these codes sets `wr_valid`. It also sets a contiguous run of 2^code enable bits, beginning at lane `req_addr[4:0]`. Enable bit i covers bits 8i+7..8i of `wr_data`.
- R4: Byte j of `req_data` (bits 8j+7..8j) appears on lane `req_addr[4:0]`+j. Lanes that are not enabled carry zero.
- R5: Size code 5 means 32 bytes. It is accepted only when `cfg_wide_en` is 1 and `req_src_aux` is 1. It then enables all 32 lanes and passes `req_data` through unchanged.
- R6: A size-5 request with `cfg_wide_en` at 0 or `req_src_aux` at 0 is rejected.
- R7: A request is rejected if `req_addr[4:0]` is not a multiple of its byte count.
- R8: Size codes 6 and 7 are always rejected.
- R9: A rejected request gives `wr_err`=1, `wr_valid`=0, `wr_be`=0 and `wr_data`=0 for exactly one cycle. `wr_valid` and `wr_err` are never high together.
- R10: Address bits above bit 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A store request is present |
| req_addr | input | 42 | Byte address of the store |
| req_size | input | 3 | Size code, 2^code bytes |
| req_src_aux | input | 1 | The request comes from the auxiliary execution unit |
| cfg_wide_en | input | 1 | Mode bit that enables 32-byte writes |
| req_data | input | 256 | Store data, packed at the low end |
| wr_valid | output | 1 | An accepted write is on the bus |
| wr_err | output | 1 | The request was rejected (one-cycle pulse) |
| wr_be | output | 32 | Byte enables, one per lane |
| wr_data | output | 256 | Store data steered onto its lanes |

## Verification
The alignment test and the wide-write gate can both trip on the same request. A misaligned 32-byte request sent while the mode is off, or from a non-auxiliary source, trips both at once. The bench sends such requests directly and in random mixtures. It checks that they produce a single error pulse with no enables set and `wr_valid` low. Accepted and rejected requests are also sent back to back, so that an error pulse from one cycle cannot spill into the valid write of the next.

// File: rtl/store_lane_pkg.sv
package store_lane_pkg;
   localparam int unsigned SIZE_CODE_W = 3;

   typedef enum logic [SIZE_CODE_W-1:0] {
      SZ_B1  = 3'd0,
      SZ_B2  = 3'd1,
      SZ_B4  = 3'd2,
      SZ_B8  = 3'd3,
      SZ_B16 = 3'd4,
      SZ_B32 = 3'd5,
      SZ_RSV6 = 3'd6,
      SZ_RSV7 = 3'd7
   } size_code_e;

   typedef struct packed {
      logic accept;
      logic reject;
   } verdict_t;
endpackage

// File: rtl/store_req_check.sv
module store_req_check
   import store_lane_pkg::*;
#(
   parameter int unsigned OFF_W = 5
) (
   input  logic [SIZE_CODE_W-1:0] size_code,
   input  logic [OFF_W-1:0]       lane_off,
   input  logic                   req_valid,
   input  logic                   wide_mode,
   input  logic                   src_aux,
   output verdict_t               verdict
);
   localparam int unsigned WIDE_CODE = OFF_W;

   logic code_known;
   logic wide_req;
   logic wide_ok;
   logic [OFF_W-1:0] low_bits;
   logic aligned;

   always_comb begin
      code_known = (int'(size_code) <= WIDE_CODE);
      wide_req   = (int'(size_code) == WIDE_CODE);
      wide_ok    = wide_mode && src_aux;
      low_bits   = ~({OFF_W{1'b1}} << size_code);
      aligned    = ((lane_off & low_bits) == '0);
      verdict.accept = req_valid && code_known && aligned && (!wide_req || wide_ok);
      verdict.reject = req_valid && !verdict.accept;
   end
endmodule

// File: rtl/store_lane_mask.sv
module store_lane_mask
   import store_lane_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned OFF_W = 5
) (
   input  logic [SIZE_CODE_W-1:0] size_code,
   input  logic [OFF_W-1:0]       lane_off,
   output logic [LANES-1:0]       lane_on
);
   localparam int unsigned SPAN_W = OFF_W + 2;

   logic [SPAN_W-1:0] run_len;
   logic [SPAN_W-1:0] run_start;
   logic [SPAN_W-1:0] run_end;

   always_comb begin
      run_len   = (int'(size_code) <= OFF_W) ? (SPAN_W'(1) << size_code) : '0;
      run_start = SPAN_W'(lane_off);
      run_end   = run_start + run_len;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [SPAN_W-1:0] IDX = SPAN_W'(g);
      assign lane_on[g] = (IDX >= run_start) && (IDX < run_end);
   end
endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
   import store_lane_pkg::*;
#(
   parameter int unsigned ADDR_W    = 42,
   parameter int unsigned BUS_BYTES = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [SIZE_CODE_W-1:0]   req_size,
   input  logic                     req_src_aux,
   input  logic                     cfg_wide_en,
   input  logic [BUS_BYTES*8-1:0]   req_data,
   output logic                     wr_valid,
   output logic                     wr_err,
   output logic [BUS_BYTES-1:0]     wr_be,
   output logic [BUS_BYTES*8-1:0]   wr_data
);
   localparam int unsigned BUS_W = BUS_BYTES * 8;
   localparam int unsigned OFF_W = $clog2(BUS_BYTES);

   initial begin
      assert (BUS_BYTES >= 2 && (1 << OFF_W) == BUS_BYTES)
         else $error("BUS_BYTES must be a power of two");
      assert (OFF_W < (1 << SIZE_CODE_W))
         else $error("size code too narrow for BUS_BYTES");
      assert (ADDR_W > OFF_W)
         else $error("ADDR_W must exceed the lane offset width");
   end

   logic [OFF_W-1:0] lane_off;
   verdict_t         verdict;
   logic [BUS_BYTES-1:0] lane_on;
   logic [BUS_W-1:0]     shifted;
   logic [BUS_W-1:0]     masked;

   assign lane_off = req_addr[OFF_W-1:0];

   store_req_check #(.OFF_W(OFF_W)) i_check (
      .size_code (req_size),
      .lane_off  (lane_off),
      .req_valid (req_valid),
      .wide_mode (cfg_wide_en),
      .src_aux   (req_src_aux),
      .verdict   (verdict)
   );

   store_lane_mask #(.LANES(BUS_BYTES), .OFF_W(OFF_W)) i_mask (
      .size_code (req_size),
      .lane_off  (lane_off),
      .lane_on   (lane_on)
   );

   assign shifted = req_data << {lane_off, 3'b000};

   for (genvar g = 0; g < BUS_BYTES; g++) begin : g_steer
      assign masked[g*8 +: 8] = lane_on[g] ? shifted[g*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_err   <= 1'b0;
         wr_be    <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= verdict.accept;
         wr_err   <= verdict.reject;
         wr_be    <= verdict.accept ? lane_on : '0;
         wr_data  <= verdict.accept ? masked  : '0;
      end
   end

   AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_err)); // R9
   AST_ERR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (wr_be == '0 && wr_data == '0)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!wr_valid && !wr_err && wr_be == '0)); // R2
   AST_VALID_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_be) != 0 && $countones(wr_be & (wr_be >> 1)) == $countones(wr_be) - 1)); // R3
   AST_WIDE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && int'(req_size) == OFF_W && !(cfg_wide_en && req_src_aux)) |=> wr_err); // R6
   AST_RSV_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && int'(req_size) > OFF_W) |=> (wr_err && !wr_valid)); // R8
endmodule

// File: tb/test_store_lane_steer.sv
module test_store_lane_steer;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 42;
   localparam int NB = 32;
   localparam int BW = NB * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0] req_size = '0;
   logic req_src_aux = 1'b0;
   logic cfg_wide_en = 1'b0;
   logic [BW-1:0] req_data = '0;
   logic wr_valid, wr_err;
   logic [NB-1:0] wr_be;
   logic [BW-1:0] wr_data;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   store_lane_steer i_store_lane_steer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_src_aux(req_src_aux), .cfg_wide_en(cfg_wide_en),
      .req_data(req_data), .wr_valid(wr_valid), .wr_err(wr_err),
      .wr_be(wr_be), .wr_data(wr_data));

   task automatic check_out(string tag, logic ev, logic ee,
                            logic [NB-1:0] ebe, logic [BW-1:0] ed);
      checks++;
      if (wr_valid !== ev || wr_err !== ee || wr_be !== ebe || wr_data !== ed) begin
         errors++;
         $display("FAIL %s: valid=%0b err=%0b be=%h data=%h expected valid=%0b err=%0b be=%h data=%h",
                  tag, wr_valid, wr_err, wr_be, wr_data, ev, ee, ebe, ed);
      end
   endtask

   // Behavioural reference of one request, then compare one edge later.
   task automatic step(string tag, logic v, logic [AW-1:0] a, logic [2:0] sz,
                       logic aux, logic wide, logic [BW-1:0] d);
      int bytes;
      int off;
      logic ok;
      logic [NB-1:0] ebe;
      logic [BW-1:0] ed;
      @(negedge clk);
      req_valid = v; req_addr = a; req_size = sz;
      req_src_aux = aux; cfg_wide_en = wide; req_data = d;
      off = int'(a[4:0]);
      bytes = (sz <= 3'd5) ? (1 << sz) : 0;
      ok = v && (sz <= 3'd4 || (sz == 3'd5 && wide && aux)) && (bytes != 0) && (off % bytes == 0);
      ebe = '0; ed = '0;
      if (ok) begin
         for (int j = 0; j < bytes; j++) begin
            ebe[off + j] = 1'b1;
            ed[(off + j)*8 +: 8] = d[j*8 +: 8];
         end
      end
      @(posedge clk); #1;
      check_out(tag, ok, v && !ok, ebe, ed);
   endtask

   function automatic logic [BW-1:0] pattern(int seed);
      logic [BW-1:0] p;
      for (int k = 0; k < NB; k++) p[k*8 +: 8] = 8'(seed * 37 + k * 11 + 1);
      return p;
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_out("R1 in reset", 1'b0, 1'b0, '0, '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check_out("R1 after reset", 1'b0, 1'b0, '0, '0);

      step("R2 idle", 1'b0, 42'h1f, 3'd4, 1'b1, 1'b1, pattern(1));
      for (int s = 0; s <= 4; s++)
         for (int o = 0; o < 32; o += (1 << s))
            step("R3 R4 aligned sizes", 1'b1, AW'(o), 3'(s), 1'b0, 1'b0, pattern(o + s));
      step("R5 wide allowed", 1'b1, 42'h3_0000_0000, 3'd5, 1'b1, 1'b1, pattern(7));
      step("R6 wide no mode", 1'b1, 42'h0, 3'd5, 1'b1, 1'b0, pattern(8));
      step("R6 wide not aux", 1'b1, 42'h0, 3'd5, 1'b0, 1'b1, pattern(9));
      step("R6 R7 wide misaligned no mode", 1'b1, 42'h10, 3'd5, 1'b0, 1'b0, pattern(10));
      step("R7 wide misaligned allowed", 1'b1, 42'h10, 3'd5, 1'b1, 1'b1, pattern(11));
      step("R7 half misaligned", 1'b1, 42'h8, 3'd4, 1'b0, 1'b0, pattern(12));
      step("R7 word misaligned", 1'b1, 42'h3, 3'd2, 1'b0, 1'b0, pattern(13));
      step("R8 code 6", 1'b1, 42'h0, 3'd6, 1'b1, 1'b1, pattern(14));
      step("R8 code 7", 1'b1, 42'h0, 3'd7, 1'b1, 1'b1, pattern(15));
      step("R9 good after err", 1'b1, 42'h4, 3'd2, 1'b0, 1'b0, pattern(16));
      step("R9 err after good", 1'b1, 42'h5, 3'd1, 1'b0, 1'b0, pattern(17));
      step("R9 idle after err", 1'b0, 42'h0, 3'd0, 1'b0, 1'b0, pattern(18));
      step("R10 high address bits", 1'b1, 42'h2AA_AAAA_AA8, 3'd3, 1'b0, 1'b0, pattern(19));
      step("R10 high address bits", 1'b1, 42'h3FF_FFFF_FFE0, 3'd5, 1'b1, 1'b1, pattern(20));
      for (int r = 0; r < 400; r++) begin
         logic [AW-1:0] ra;
         ra = {$urandom, $urandom};
         step("R2 R3 R6 R7 R9 random mix", ($urandom % 5) != 0, ra, 3'($urandom),
              1'($urandom), 1'($urandom), {8{$urandom}});
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule